// File: doc/BRIEF.md
# Command-Sequence Write Lock

This block decides what happens to each write strobe accepted on the parallel bus before it reaches the page-load logic of a non-volatile memory. It compares the address/data pairs against two fixed command patterns. One is a three-write unlock/enable pattern. The other is a six-write disable pattern. The block also holds a persistent protection flag. For every strobe it raises exactly one of three qualifiers:
- **pass**: the byte goes to the page latch.
- **command**: the byte is swallowed and never stored.
- **dummy start**: the byte is thrown away, but the page controller still starts its busy timer, so that reads during that time act as status polling.

Command bytes must follow the same load-gap rule as a page load. If the gap to the next byte is too long, a partial pattern is abandoned. When the enable pattern completes, writes in the same load window pass. When that window closes (the point where programming would begin), the protection flag sets. While protection is set, a write is stored only if the enable pattern comes directly before it. The disable pattern clears the flag at once. Both patterns and the gap limit are parameters.

Top module: `swp_lock_top`

## Requirements
- R1: After reset, protectOn is 0, and a write whose address/data is not the first enable pair gets passWr.
- R2: With protection off and no pattern in progress, a write that does not match the first pattern pair gets passWr=1, cmdWr=0 and dummyStart=0.
- R3: A write that matches the next expected pair of the enable or disable pattern gets cmdWr and is never passed. The default enable pattern is 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0. The address is 15 bits and the data is 8 bits.
- R4: After the enable pattern completes, writes in the same load window get passWr. protectOn rises exactly GAP_CYCLES+1 cycles after the last strobe of the window, and not earlier.
- R5: With protection on and no pattern before it, an ordinary write gets dummyStart=1 and passWr=0.
- R6: With protection on, an enable pattern followed by a write passes that write, and protection stays on afterwards.
- R7: A mismatching write part-way through a pattern returns the detector to idle. That write is handled as an ordinary write: passWr if unprotected, dummyStart if protected.
- R8: If more than GAP_CYCLES cycles pass between pattern bytes, the pattern is aborted, and the next byte is handled as an ordinary write.
- R9: The default disable pattern is 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20. Completing it clears protectOn in the cycle after its last strobe. Later writes pass.
- R10: Each strobe raises exactly one of passWr, cmdWr and dummyStart. Without a strobe, none of the three is raised.
- R11: A pattern byte that arrives exactly GAP_CYCLES cycles after the previous one still continues the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | One-cycle pulse per accepted write |
| wrAddr | input | AW | Write address |
| wrData | input | DW | Write data |
| passWr | output | 1 | Forward this write to the page latch |
| cmdWr | output | 1 | Write consumed as pattern byte |
| dummyStart | output | 1 | Write discarded; start the busy timer |
| protectOn | output | 1 | Protection flag |

## Verification
Random writes to addresses outside the pattern set are applied in both protection states. They separate the pass outcome from the dummy-start outcome. Directed patterns cover the remaining cases:
- Broken patterns and mid-pattern mismatches show the return to idle.
- Gaps of exactly GAP_CYCLES and of GAP_CYCLES+1 locate the edge of the load window.
- Complete enable and disable patterns, timed to the cycle, show when the flag moves and whether the unlocked window passes its writes.

// File: rtl/swp_lock_pkg.sv
package swp_lock_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic gapRestart;
    logic windowOpen;
  } swp_ctl_t;

  // results from datapath to control
  typedef struct packed {
    logic enHit;
    logic disHit;
    logic gapExpire;
  } swp_stat_t;
endpackage

// File: rtl/swp_lock_datapath.sv
module swp_lock_datapath
  import swp_lock_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int EN_LEN = 3,
  parameter int DIS_LEN = 6,
  parameter int GAP_CYCLES = 256,
  parameter int STEP_W = 3,
  parameter logic [AW-1:0] EN_ADDR [EN_LEN] = '{15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [DW-1:0] EN_DATA [EN_LEN] = '{8'hAA, 8'h55, 8'hA0},
  parameter logic [AW-1:0] DIS_ADDR [DIS_LEN] = '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [DW-1:0] DIS_DATA [DIS_LEN] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic [STEP_W-1:0] step,
  input  swp_ctl_t          ctl,
  output swp_stat_t         stat
);
  localparam int CNT_W = (GAP_CYCLES > 2) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYCLES - 1);

  logic [EN_LEN-1:0]  enHitVec;
  logic [DIS_LEN-1:0] disHitVec;
  logic [CNT_W-1:0]   gapCnt;

  for (genvar i = 0; i < EN_LEN; i++) begin : g_en
    assign enHitVec[i] = (wrAddr == EN_ADDR[i]) && (wrData == EN_DATA[i]);
  end
  for (genvar j = 0; j < DIS_LEN; j++) begin : g_dis
    assign disHitVec[j] = (wrAddr == DIS_ADDR[j]) && (wrData == DIS_DATA[j]);
  end

  always_comb begin
    stat.enHit  = 1'b0;
    stat.disHit = 1'b0;
    for (int i = 0; i < EN_LEN; i++)
      if (step == STEP_W'(i)) stat.enHit = enHitVec[i];
    for (int j = 0; j < DIS_LEN; j++)
      if (step == STEP_W'(j)) stat.disHit = disHitVec[j];
    stat.gapExpire = ctl.windowOpen && !ctl.gapRestart && (gapCnt == CNT_LAST);
  end

  // cycles since the last strobe while a window is open
  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= '0;
    else if (ctl.gapRestart || !ctl.windowOpen) gapCnt <= '0;
    else if (gapCnt != CNT_LAST) gapCnt <= gapCnt + CNT_W'(1);
  end
endmodule

// File: rtl/swp_lock_ctrl.sv
module swp_lock_ctrl
  import swp_lock_pkg::*;
#(
  parameter int EN_LEN = 3,
  parameter int DIS_LEN = 6,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  swp_stat_t         stat,
  output swp_ctl_t          ctl,
  output logic [STEP_W-1:0] step,
  output logic              passWr,
  output logic              cmdWr,
  output logic              dummyStart,
  output logic              protectOn
);
  localparam logic [STEP_W-1:0] EN_END  = STEP_W'(EN_LEN - 1);
  localparam logic [STEP_W-1:0] DIS_END = STEP_W'(DIS_LEN - 1);

  logic enOk, disOk, armed, pendEn, protect;
  logic [STEP_W-1:0] stepN;
  logic enOkN, disOkN, armedN, pendEnN, protectN;
  logic enM, disM;

  assign enM = enOk && stat.enHit;
  assign disM = disOk && stat.disHit;
  assign ctl.gapRestart = wrStrobe;
  assign ctl.windowOpen = armed || (step != '0);
  assign protectOn = protect;

  always_comb begin
    stepN = step; enOkN = enOk; disOkN = disOk;
    armedN = armed; pendEnN = pendEn; protectN = protect;
    passWr = 1'b0; cmdWr = 1'b0; dummyStart = 1'b0;
    if (wrStrobe) begin
      if (armed) begin
        passWr = 1'b1;
      end else if (enM || disM) begin
        cmdWr = 1'b1;
        if (enM && step == EN_END) begin
          armedN = 1'b1; pendEnN = 1'b1;
          stepN = '0; enOkN = 1'b1; disOkN = 1'b1;
        end else if (disM && step == DIS_END) begin
          armedN = 1'b1; pendEnN = 1'b0; protectN = 1'b0;
          stepN = '0; enOkN = 1'b1; disOkN = 1'b1;
        end else begin
          stepN = step + STEP_W'(1); enOkN = enM; disOkN = disM;
        end
      end else begin
        stepN = '0; enOkN = 1'b1; disOkN = 1'b1;
        passWr = !protect;
        dummyStart = protect;
      end
    end else if (stat.gapExpire) begin
      stepN = '0; enOkN = 1'b1; disOkN = 1'b1;
      armedN = 1'b0;
      if (pendEn) protectN = 1'b1;
      pendEnN = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step <= '0; enOk <= 1'b1; disOk <= 1'b1;
      armed <= 1'b0; pendEn <= 1'b0; protect <= 1'b0;
    end else begin
      step <= stepN; enOk <= enOkN; disOk <= disOkN;
      armed <= armedN; pendEn <= pendEnN; protect <= protectN;
    end
  end
endmodule

// File: rtl/swp_lock_top.sv
module swp_lock_top
  import swp_lock_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int EN_LEN = 3,
  parameter int DIS_LEN = 6,
  parameter int GAP_CYCLES = 256,
  parameter logic [AW-1:0] EN_ADDR [EN_LEN] = '{15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [DW-1:0] EN_DATA [EN_LEN] = '{8'hAA, 8'h55, 8'hA0},
  parameter logic [AW-1:0] DIS_ADDR [DIS_LEN] = '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [DW-1:0] DIS_DATA [DIS_LEN] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20}
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrStrobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic          passWr,
  output logic          cmdWr,
  output logic          dummyStart,
  output logic          protectOn
);
  localparam int MAX_LEN = (DIS_LEN > EN_LEN) ? DIS_LEN : EN_LEN;
  localparam int STEP_W = $clog2(MAX_LEN + 1);

  swp_ctl_t          ctl;
  swp_stat_t         stat;
  logic [STEP_W-1:0] step;

  swp_lock_datapath #(
    .AW(AW), .DW(DW), .EN_LEN(EN_LEN), .DIS_LEN(DIS_LEN),
    .GAP_CYCLES(GAP_CYCLES), .STEP_W(STEP_W),
    .EN_ADDR(EN_ADDR), .EN_DATA(EN_DATA),
    .DIS_ADDR(DIS_ADDR), .DIS_DATA(DIS_DATA)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .step(step), .ctl(ctl), .stat(stat)
  );

  swp_lock_ctrl #(
    .EN_LEN(EN_LEN), .DIS_LEN(DIS_LEN), .STEP_W(STEP_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .stat(stat),
    .ctl(ctl), .step(step), .passWr(passWr), .cmdWr(cmdWr),
    .dummyStart(dummyStart), .protectOn(protectOn)
  );
endmodule

// File: rtl/swp_lock_chk.sv
module swp_lock_chk (
  input logic clk,
  input logic rstN,
  input logic wrStrobe,
  input logic passWr,
  input logic cmdWr,
  input logic dummyStart,
  input logic protectOn
);
  // R10: one qualifier per strobe
  a_r10_one_class: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> ($countones({passWr, cmdWr, dummyStart}) == 1));
  // R10: silence without a strobe
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> !(passWr || cmdWr || dummyStart));
  // R2: no discard while unprotected
  a_r2_unprot_no_drop: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !protectOn) |-> !dummyStart);
  // R5: a discard only happens under protection
  a_r5_drop_needs_prot: assert property (@(posedge clk) disable iff (!rstN)
    dummyStart |-> protectOn);
  // R4: protection rises only when a window closes without a strobe
  a_r4_rise_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protectOn) |-> $past(!wrStrobe));
  // R9: protection falls only on a command byte
  a_r9_fall_on_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protectOn) |-> $past(wrStrobe && cmdWr));
endmodule

bind swp_lock_top swp_lock_chk chk_i (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .passWr(passWr),
  .cmdWr(cmdWr), .dummyStart(dummyStart), .protectOn(protectOn)
);

// File: tb/swp_lock_top_tb_top.sv
module swp_lock_top_tb_top;
  localparam int GAP = 16;
  localparam int K_PASS = 0, K_CMD = 1, K_DROP = 2, K_BAD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStrobe = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic passWr, cmdWr, dummyStart, protectOn;
  int nVec = 0;
  int nBad = 0;
  int lastKind;

  always #2 clk = ~clk;

  swp_lock_top #(.GAP_CYCLES(GAP)) dut_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .passWr(passWr), .cmdWr(cmdWr), .dummyStart(dummyStart), .protectOn(protectOn)
  );

  function automatic int ordinaryKind(input logic prot);
    return prot ? K_DROP : K_PASS;
  endfunction

  function automatic logic [14:0] plainAddr(input logic [31:0] r);
    logic [14:0] a = r[14:0];
    if (a == 15'h5555 || a == 15'h2AAA) a = a ^ 15'h0001;
    return a;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wrStrobe = 1'b1; wrAddr = a; wrData = d;
    #1;
    if ($countones({passWr, cmdWr, dummyStart}) != 1) lastKind = K_BAD;
    else if (passWr) lastKind = K_PASS;
    else if (cmdWr) lastKind = K_CMD;
    else lastKind = K_DROP;
    @(posedge clk);
    #1 wrStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enableSeq(input string tag);
    wr(15'h5555, 8'hAA); check(tag, lastKind, K_CMD);
    wr(15'h2AAA, 8'h55); check(tag, lastKind, K_CMD);
    wr(15'h5555, 8'hA0); check(tag, lastKind, K_CMD);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    #800000;
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    check("R1 protect reset", int'(protectOn), 0);
    wr(15'h0100, 8'h11); check("R1 first write", lastKind, K_PASS);

    for (int i = 0; i < 40; i++) begin
      wr(plainAddr($urandom), 8'($urandom));
      check("R2 random unprotected", lastKind, ordinaryKind(1'b0));
    end

    // R3 and R7: partial pattern, then a mismatch
    wr(15'h5555, 8'hAA); check("R3 first pair", lastKind, K_CMD);
    wr(15'h2AAA, 8'h55); check("R3 second pair", lastKind, K_CMD);
    wr(15'h1234, 8'h00); check("R7 mismatch unprotected", lastKind, K_PASS);
    wr(15'h2AAA, 8'h55); check("R7 back to idle", lastKind, K_PASS);

    // R8: gap too long
    wr(15'h5555, 8'hAA); check("R8 first pair", lastKind, K_CMD);
    idle(GAP);
    wr(15'h2AAA, 8'h55); check("R8 abort after gap", lastKind, K_PASS);

    // R11 and R4: enable pattern at the gap limit, timed protection rise
    wr(15'h5555, 8'hAA); check("R11 first pair", lastKind, K_CMD);
    idle(GAP - 1);
    wr(15'h2AAA, 8'h55); check("R11 at gap limit", lastKind, K_CMD);
    idle(GAP - 1);
    wr(15'h5555, 8'hA0); check("R11 third pair", lastKind, K_CMD);
    wr(15'h0300, 8'h33); check("R4 window write", lastKind, K_PASS);
    check("R4 not yet", int'(protectOn), 0);
    idle(GAP - 1);
    check("R4 not early", int'(protectOn), 0);
    idle(1);
    check("R4 rise", int'(protectOn), 1);

    for (int i = 0; i < 30; i++) begin
      wr(plainAddr($urandom), 8'($urandom));
      check("R5 random protected", lastKind, ordinaryKind(1'b1));
    end

    wr(15'h5555, 8'hAA); check("R7 prot first pair", lastKind, K_CMD);
    wr(15'h0400, 8'h44); check("R7 mismatch protected", lastKind, K_DROP);

    // R6: unlocked protected write
    enableSeq("R6 unlock pattern");
    wr(15'h0500, 8'h55); check("R6 unlocked write", lastKind, K_PASS);
    wr(15'h0501, 8'h56); check("R6 page second byte", lastKind, K_PASS);
    idle(GAP + 2);
    check("R6 still protected", int'(protectOn), 1);
    wr(15'h0502, 8'h57); check("R6 relocked", lastKind, K_DROP);

    // R9: disable
    wr(15'h5555, 8'hAA); check("R9 d0", lastKind, K_CMD);
    wr(15'h2AAA, 8'h55); check("R9 d1", lastKind, K_CMD);
    wr(15'h5555, 8'h80); check("R9 d2", lastKind, K_CMD);
    wr(15'h5555, 8'hAA); check("R9 d3", lastKind, K_CMD);
    wr(15'h2AAA, 8'h55); check("R9 d4", lastKind, K_CMD);
    check("R9 not cleared early", int'(protectOn), 1);
    wr(15'h5555, 8'h20); check("R9 d5", lastKind, K_CMD);
    check("R9 cleared", int'(protectOn), 0);
    wr(15'h0600, 8'h66); check("R9 window write", lastKind, K_PASS);
    idle(GAP + 2);
    check("R9 stays off", int'(protectOn), 0);
    for (int i = 0; i < 20; i++) begin
      wr(plainAddr($urandom), 8'($urandom));
      check("R10 random after disable", lastKind, ordinaryKind(protectOn));
    end
    report();
  end
endmodule